// File: doc/BRIEF.md
# Three-Level Interrupt Link Inserter

This block sits beside an in-order core that spends two clocks on each instruction. It decides the cycle in which a call-style link instruction is injected into the pipeline on behalf of one of three prioritized interrupt levels. Level 0 has the highest priority. Each level watches one raw event line, chosen by a per-level source selector. The block reports which level was taken and the vector address that level jumps to. Executing the link and fetching from the vector belong to the core, and the event generators are outside the block.

Insertion happens only at an instruction boundary. It is withheld while a multi-cycle instruction or a hardware repeat loop is in progress, and while a global hold is engaged. Requests that are seen during any of these windows stay pending and are served later, in priority order. Every inserted link and every return strobe is followed by a one-cycle bubble request, which makes the core issue a forced no-op.

Top module: `isr_link_ctl`

## Requirements
- R1: When several levels are eligible in the same cycle, the lowest-numbered level is inserted first. `ins_lvl_o` carries the level as an unsigned number.
- R2: Level L raises a request when `evt_i[s-1]` is high, where s is its selector value. Writing selector 0 through `cfg_we_i[L]`/`cfg_sel_i` disables the level and discards any request it has pending. A later write of a nonzero selector starts the level clean, watching the new event line.
- R3: A request is taken from the raw event in its first cycle. If insertion is possible in that cycle, `ins_o` is high in that same cycle.
- R4: A `hold_set_i` pulse engages the hold from the next cycle, and no insertion happens while it is engaged. A `hold_rel_i` pulse releases it. Requests that arrive while held are kept and served in priority order after release. A simultaneous set and release leaves the hold engaged.
- R5: `ins_o` is high only in a cycle where `slot_i` is high and `busy_i` is low.
- R6: `ins_o` is never high while `rep_i` is high.
- R7: `bubble_o` is high for exactly the one cycle after each insertion and after each cycle with any `ret_i` bit set. No insertion happens in a bubble cycle.
- R8: A pending level is inserted only while no level of equal or higher priority is active. Insertion makes the level active, and `ret_i[L]` clears it. While level 0 is active, nothing is inserted.
- R9: Several requests on a level that is already pending merge into one, and that level is inserted once.
- R10: Reset (`rst_ni` low) clears the selectors and all pending, active, hold and bubble state.
- R11: `ins_vec_o` equals `VEC_BASE + 2*level` during an insertion. With the default parameters this is 0x1F0, 0x1F2 or 0x1F4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | NUM_LVL | Per-level selector write strobe |
| cfg_sel_i | input | SEL_W | Selector value to write (0 = disabled) |
| evt_i | input | 2**SEL_W-1 | Raw event pulses; selector s watches bit s-1 |
| hold_set_i | input | 1 | Engage the global hold |
| hold_rel_i | input | 1 | Release the global hold |
| slot_i | input | 1 | Core is at an instruction boundary |
| busy_i | input | 1 | Multi-cycle instruction in progress |
| rep_i | input | 1 | Hardware repeat loop active |
| ret_i | input | NUM_LVL | Return-from-level strobes |
| ins_o | output | 1 | Insert link now |
| ins_lvl_o | output | LVL_W | Level being inserted |
| ins_vec_o | output | VEC_W | Vector address of that level |
| bubble_o | output | 1 | Force a no-op slot this cycle |

## Verification
The assertions check the cycle-level gating on every cycle: that insertion happens only at a free boundary, outside repeat loops, holds and bubbles, and never under an equal or higher active level. They also check that a bubble follows each insertion. The bench scenarios are the only place that shows the ordering and the retention: requests kept across a hold, a busy or a repeat window and then served in priority order, and merged requests producing a single link. They also cover the effects of selector changes on pending state, the same-cycle capture of a raw event, nested preemption, and the reset clearing of held and active state.

// File: rtl/isr_pkg.sv
package isr_pkg;
  typedef enum logic [1:0] {
    HOLD_KEEP = 2'd0,
    HOLD_ON   = 2'd1,
    HOLD_OFF  = 2'd2
  } hold_op_e;

  // engage wins when both strobes coincide
  function automatic hold_op_e hold_decode(input logic set_i, input logic rel_i);
    if (set_i)      return HOLD_ON;
    else if (rel_i) return HOLD_OFF;
    else            return HOLD_KEEP;
  endfunction

  function automatic logic hold_next(input hold_op_e op, input logic q);
    case (op)
      HOLD_ON:  return 1'b1;
      HOLD_OFF: return 1'b0;
      default:  return q;
    endcase
  endfunction
endpackage

// File: rtl/isr_src_sel.sv
module isr_src_sel #(
  parameter int unsigned SEL_W   = 3,
  localparam int unsigned NUM_SRC = (1 << SEL_W) - 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [NUM_SRC-1:0] evt_i,
  output logic               req_o,
  output logic               clr_o
);
  logic [SEL_W-1:0] sel_q;
  logic [NUM_SRC:0] evt_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sel_q <= '0;
    else if (we_i) sel_q <= sel_i;
  end

  // slot 0 of the extended vector is tied low: selector 0 never fires
  assign evt_ext = {evt_i, 1'b0};
  assign req_o   = evt_ext[sel_q];
  assign clr_o   = we_i && (sel_i == '0);
endmodule

// File: rtl/isr_arb.sv
module isr_arb #(
  parameter int unsigned NUM_LVL = 3,
  localparam int unsigned LVL_W  = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1
) (
  input  logic [NUM_LVL-1:0] cand_i,
  input  logic [NUM_LVL-1:0] act_i,
  output logic               any_o,
  output logic [NUM_LVL-1:0] gnt_o,
  output logic [LVL_W-1:0]   lvl_o
);
  logic [NUM_LVL-1:0] elig;

  // a level is blocked by itself or any higher-priority active level
  always_comb begin
    logic blk;
    blk = 1'b0;
    for (int l = 0; l < NUM_LVL; l++) begin
      blk     = blk | act_i[l];
      elig[l] = cand_i[l] & ~blk;
    end
  end

  always_comb begin
    logic found;
    found = 1'b0;
    gnt_o = '0;
    lvl_o = '0;
    for (int l = 0; l < NUM_LVL; l++) begin
      if (elig[l] && !found) begin
        found    = 1'b1;
        gnt_o[l] = 1'b1;
        lvl_o    = LVL_W'(l);
      end
    end
    any_o = found;
  end
endmodule

// File: rtl/isr_state.sv
module isr_state
  import isr_pkg::*;
#(
  parameter int unsigned NUM_LVL = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_LVL-1:0] req_i,
  input  logic [NUM_LVL-1:0] clr_i,
  input  logic [NUM_LVL-1:0] gnt_i,
  input  logic               fire_i,
  input  logic [NUM_LVL-1:0] ret_i,
  input  hold_op_e           hold_op_i,
  output logic [NUM_LVL-1:0] pend_o,
  output logic [NUM_LVL-1:0] act_o,
  output logic               hold_o,
  output logic               bub_o
);
  logic [NUM_LVL-1:0] pend_q, act_q, taken;
  logic               hold_q, bub_q;

  assign taken = fire_i ? gnt_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      act_q  <= '0;
      hold_q <= 1'b0;
      bub_q  <= 1'b0;
    end else begin
      // same-level requests fold into one bit; taken level is consumed
      pend_q <= (pend_q | req_i) & ~clr_i & ~taken;
      act_q  <= (act_q & ~ret_i) | taken;
      hold_q <= hold_next(hold_op_i, hold_q);
      bub_q  <= fire_i | (|ret_i);
    end
  end

  assign pend_o = pend_q;
  assign act_o  = act_q;
  assign hold_o = hold_q;
  assign bub_o  = bub_q;
endmodule

// File: rtl/isr_link_ctl.sv
module isr_link_ctl
  import isr_pkg::*;
#(
  parameter int unsigned NUM_LVL  = 3,
  parameter int unsigned SEL_W    = 3,
  parameter int unsigned VEC_W    = 9,
  parameter logic [VEC_W-1:0] VEC_BASE = 9'h1F0,
  localparam int unsigned NUM_SRC = (1 << SEL_W) - 1,
  localparam int unsigned LVL_W   = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_LVL-1:0] cfg_we_i,
  input  logic [SEL_W-1:0]   cfg_sel_i,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               hold_set_i,
  input  logic               hold_rel_i,
  input  logic               slot_i,
  input  logic               busy_i,
  input  logic               rep_i,
  input  logic [NUM_LVL-1:0] ret_i,
  output logic               ins_o,
  output logic [LVL_W-1:0]   ins_lvl_o,
  output logic [VEC_W-1:0]   ins_vec_o,
  output logic               bubble_o
);
  logic [NUM_LVL-1:0] req, clr, pend_w, act_w, gnt;
  logic [LVL_W-1:0]   lvl;
  logic               any, hold_w, bub_w, gate_ok, fire;

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_src
    isr_src_sel #(.SEL_W(SEL_W)) u_src (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .we_i  (cfg_we_i[g]),
      .sel_i (cfg_sel_i),
      .evt_i (evt_i),
      .req_o (req[g]),
      .clr_o (clr[g])
    );
  end

  // raw event counts in its own cycle, not only after it is latched
  isr_arb #(.NUM_LVL(NUM_LVL)) u_arb (
    .cand_i(pend_w | (req & ~clr)),
    .act_i (act_w),
    .any_o (any),
    .gnt_o (gnt),
    .lvl_o (lvl)
  );

  assign gate_ok = slot_i && !busy_i && !rep_i && !hold_w && !bub_w;
  assign fire    = any && gate_ok;

  isr_state #(.NUM_LVL(NUM_LVL)) u_state (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req),
    .clr_i    (clr),
    .gnt_i    (gnt),
    .fire_i   (fire),
    .ret_i    (ret_i),
    .hold_op_i(hold_decode(hold_set_i, hold_rel_i)),
    .pend_o   (pend_w),
    .act_o    (act_w),
    .hold_o   (hold_w),
    .bub_o    (bub_w)
  );

  assign ins_o     = fire;
  assign ins_lvl_o = fire ? lvl : '0;
  assign ins_vec_o = fire ? VEC_BASE + VEC_W'({lvl, 1'b0}) : '0;
  assign bubble_o  = bub_w;
endmodule

// File: rtl/isr_link_ctl_chk.sv
module isr_link_ctl_chk #(
  parameter int unsigned NUM_LVL = 3,
  localparam int unsigned LVL_W  = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               slot_i,
  input logic               busy_i,
  input logic               rep_i,
  input logic               ins_o,
  input logic [LVL_W-1:0]   ins_lvl_o,
  input logic               bubble_o,
  input logic [NUM_LVL-1:0] act_w,
  input logic               hold_w
);
  logic [NUM_LVL-1:0] upto_mask;
  assign upto_mask = NUM_LVL'((2 << ins_lvl_o) - 1);

  assert_free_slot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_o |-> (slot_i && !busy_i));

  assert_no_rep_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_o |-> !rep_i);

  assert_held_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_w |-> !ins_o);

  assert_bubble_after_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_o |=> bubble_o);

  assert_bubble_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bubble_o |-> !ins_o);

  assert_no_preempt_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_o |-> ((act_w & upto_mask) == '0));

  assert_top_active_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_w[0] |-> !ins_o);
endmodule

bind isr_link_ctl isr_link_ctl_chk #(.NUM_LVL(NUM_LVL)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .slot_i   (slot_i),
  .busy_i   (busy_i),
  .rep_i    (rep_i),
  .ins_o    (ins_o),
  .ins_lvl_o(ins_lvl_o),
  .bubble_o (bubble_o),
  .act_w    (act_w),
  .hold_w   (hold_w)
);

// File: tb/isr_link_ctl_test.sv
module isr_link_ctl_test;
  localparam int NL = 3;
  localparam int SW = 3;
  localparam int NS = (1 << SW) - 1;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NL-1:0] cfg_we_i = '0;
  logic [SW-1:0] cfg_sel_i = '0;
  logic [NS-1:0] evt_i = '0;
  logic          hold_set_i = 1'b0, hold_rel_i = 1'b0;
  logic          slot_i = 1'b1, busy_i = 1'b0, rep_i = 1'b0;
  logic [NL-1:0] ret_i = '0;
  logic          ins_o, bubble_o;
  logic [1:0]    ins_lvl_o;
  logic [8:0]    ins_vec_o;

  isr_link_ctl uut (.*);

  always #2.5 clk_i = ~clk_i;

  int total = 0, bad = 0, ins_seen = 0, cyc = 0;
  int exp_q[$];
  string tag_q[$];
  logic prev_ins = 1'b0, prev_ret = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // monitor: pops the scoreboard on every insertion, checks bubble timing
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      prev_ins = 1'b0;
      prev_ret = 1'b0;
    end else begin
      if (bubble_o !== (prev_ins | prev_ret))
        chk(0, "R7", "bubble_o", int'(bubble_o), int'(prev_ins | prev_ret));
      if (ins_o && bubble_o) chk(0, "R7", "insert in bubble", 1, 0);
      if (ins_o) begin
        ins_seen++;
        if (exp_q.size() == 0) chk(0, "R8", "unexpected insert lvl", int'(ins_lvl_o), -1);
        else begin
          int e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(int'(ins_lvl_o) == e, t, "ins_lvl_o", int'(ins_lvl_o), e);
          chk(int'(ins_vec_o) == 'h1F0 + 2 * e, "R11", "ins_vec_o",
              int'(ins_vec_o), 'h1F0 + 2 * e);
        end
      end
      prev_ins = ins_o;
      prev_ret = |ret_i;
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000) begin
      chk(0, "WDOG", "watchdog expired", cyc, 100000);
      finish_run();
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic expect_lvl(input int l, input string tag);
    exp_q.push_back(l);
    tag_q.push_back(tag);
  endtask

  task automatic set_sel(input int l, input int v);
    tick(1);
    cfg_we_i[l] = 1'b1;
    cfg_sel_i   = SW'(v);
    tick(1);
    cfg_we_i = '0;
  endtask

  task automatic pulse(input int idx);
    tick(1);
    evt_i[idx] = 1'b1;
    tick(1);
    evt_i = '0;
  endtask

  task automatic do_ret(input int l);
    tick(1);
    ret_i[l] = 1'b1;
    tick(1);
    ret_i = '0;
  endtask

  task automatic hold_on();
    tick(1);
    hold_set_i = 1'b1;
    tick(1);
    hold_set_i = 1'b0;
  endtask

  task automatic hold_off();
    tick(1);
    hold_rel_i = 1'b1;
    tick(1);
    hold_rel_i = 1'b0;
  endtask

  task automatic chk_count(input int exp, input string req);
    chk(ins_seen == exp, req, "insert count", ins_seen, exp);
  endtask

  task automatic cfg_all();
    set_sel(0, 1);
    set_sel(1, 2);
    set_sel(2, 3);
  endtask

  initial begin
    int base;
    tick(3);
    @(negedge clk_i);
    chk(ins_o == 1'b0, "R10", "ins_o in reset", int'(ins_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(bubble_o == 1'b0, "R10", "bubble_o after reset", int'(bubble_o), 0);
    cfg_all();

    // R3: same-cycle insertion from the raw event
    expect_lvl(2, "R3");
    tick(1);
    evt_i[2] = 1'b1;
    @(negedge clk_i);
    chk(ins_o == 1'b1, "R3", "ins_o in event cycle", int'(ins_o), 1);
    tick(1);
    evt_i = '0;
    do_ret(2);
    tick(3);
    chk_count(1, "R3");

    // R4 and R1: collected during hold, served by priority after release
    base = ins_seen;
    hold_on();
    pulse(2); pulse(1); pulse(0);
    tick(4);
    chk_count(base, "R4");
    expect_lvl(0, "R1"); expect_lvl(1, "R1"); expect_lvl(2, "R1");
    hold_off();
    tick(4);
    chk_count(base + 1, "R4");
    do_ret(0); tick(4);
    do_ret(1); tick(4);
    do_ret(2); tick(4);
    chk_count(base + 3, "R1");

    // R4: simultaneous set and release leaves the hold engaged
    base = ins_seen;
    tick(1);
    hold_set_i = 1'b1; hold_rel_i = 1'b1;
    tick(1);
    hold_set_i = 1'b0; hold_rel_i = 1'b0;
    pulse(1);
    tick(4);
    chk_count(base, "R4");
    expect_lvl(1, "R4");
    hold_off();
    tick(4);
    chk_count(base + 1, "R4");
    do_ret(1); tick(3);

    // R5: busy and no boundary both defer insertion
    base = ins_seen;
    tick(1); busy_i = 1'b1;
    pulse(1);
    tick(4);
    chk_count(base, "R5");
    expect_lvl(1, "R5");
    busy_i = 1'b0;
    tick(3);
    chk_count(base + 1, "R5");
    do_ret(1); tick(3);
    base = ins_seen;
    slot_i = 1'b0;
    pulse(2);
    tick(4);
    chk_count(base, "R5");
    expect_lvl(2, "R5");
    slot_i = 1'b1;
    tick(3);
    chk_count(base + 1, "R5");
    do_ret(2); tick(3);

    // R6: repeat loop defers insertion
    base = ins_seen;
    tick(1); rep_i = 1'b1;
    pulse(0);
    tick(5);
    chk_count(base, "R6");
    expect_lvl(0, "R6");
    rep_i = 1'b0;
    tick(3);
    chk_count(base + 1, "R6");
    do_ret(0); tick(3);

    // R8: nesting and blocking by equal or higher active levels
    base = ins_seen;
    expect_lvl(2, "R8"); pulse(2); tick(3);
    expect_lvl(1, "R8"); pulse(1); tick(3);
    pulse(2); tick(3);
    expect_lvl(0, "R8"); pulse(0); tick(3);
    pulse(1); tick(3);
    chk_count(base + 3, "R8");
    do_ret(0); tick(4);
    chk_count(base + 3, "R8");
    expect_lvl(1, "R8");
    do_ret(1); tick(4);
    chk_count(base + 4, "R8");
    do_ret(1); tick(4);
    chk_count(base + 4, "R8");
    expect_lvl(2, "R8");
    do_ret(2); tick(4);
    chk_count(base + 5, "R8");
    do_ret(2); tick(3);

    // R9: repeated requests on a pending level merge
    base = ins_seen;
    hold_on();
    pulse(1); pulse(1); pulse(1);
    expect_lvl(1, "R9");
    hold_off();
    tick(8);
    chk_count(base + 1, "R9");
    do_ret(1); tick(3);

    // R2: disabling discards pending; selector remaps the event line
    base = ins_seen;
    hold_on();
    pulse(2);
    set_sel(2, 0);
    hold_off();
    tick(5);
    chk_count(base, "R2");
    pulse(2);
    tick(3);
    chk_count(base, "R2");
    set_sel(2, 5);
    pulse(2);
    tick(3);
    chk_count(base, "R2");
    expect_lvl(2, "R2");
    pulse(4);
    tick(3);
    chk_count(base + 1, "R2");
    do_ret(2); tick(3);
    set_sel(2, 3);

    // R10: reset clears active, pending, hold and selectors
    base = ins_seen;
    expect_lvl(2, "R10"); pulse(2); tick(3);
    hold_on();
    pulse(0);
    tick(1);
    rst_ni = 1'b0;
    tick(2);
    rst_ni = 1'b1;
    pulse(0);
    tick(3);
    chk_count(base + 1, "R10");
    cfg_all();
    tick(4);
    chk_count(base + 1, "R10");
    expect_lvl(2, "R10");
    pulse(2);
    tick(3);
    chk_count(base + 2, "R10");
    do_ret(2); tick(4);

    chk(exp_q.size() == 0, "R1", "scoreboard left", exp_q.size(), 0);
    finish_run();
  end
endmodule